// File: doc/BRIEF.md
# TDM DSP-Mode Audio Serial Port

This block is the slave side of a shared serial audio link. An external master supplies the bit clock and a one-bit-wide frame-sync pulse. The block oversamples both with its own system clock. Within each frame it sends a left and a right ADC word into one of two time slots. In the same frame it collects a left and a right DAC word from a slot of its own choosing. Words are sent MSB first, and the right word follows the left word directly.

The ADC data line is shared with a second device that uses the other slot. For that reason the output enable is raised only while the block's own data bits are on the wire. If the slot word length is longer than the data width, the trailing bits of each word become a guard gap with the line released. A mono mode sends and receives only the left-channel position. A framing-variant input chooses whether the first data bit follows the frame-sync reference by one bit clock or comes on the very next one.

Top module: `tdm_dsp_port`

## Requirements
- R1: After reset, with TDM enabled, `adcdat_oe` is 0, `dac_valid` is 0, and `dac_left` and `dac_right` are zero.
- R2: The frame reference is the first BCLK rising edge at which LRCLK is sampled high after being sampled low. Data bit 0 is the bit sampled on the 2nd rising edge after the reference when `sync_late`=0, and on the 1st rising edge after the reference when `sync_late`=1. No data is driven before the first reference, and every new reference restarts bit counting.
- R3: Width codes on `dw_sel` and `sl_sel` are 0=16, 1=20, 2=24 and 3=32 bits. Slot 0 begins at data bit 0 and slot 1 begins at data bit 2×slot length. Each slot carries the left word and then the right word, and each word occupies one slot length. The first data-width bits of a word carry that word MSB first, and the word's value sits in the low data-width bits of the parallel port.
- R4: `adcdat` and `adcdat_oe` change only after a BCLK falling edge. Each ADC bit is presented during the BCLK low phase that ends at the rising edge carrying that bit.
- R5: With ADC TDM enabled, `adcdat_oe` is high only during the block's own data bits. It is low in the guard bits beyond the data width and in the other slot. It therefore never overlaps a second device that drives only the other slot's data bits.
- R6: `adc_slot` selects the transmit slot and `dac_slot` selects the receive slot, each independently of the other.
- R7: With `adc_tdm_en`=0, slot 0 is used, `adcdat_oe` stays high, and `adcdat` is 0 outside the data bits. With `dac_tdm_en`=0, reception uses slot 0.
- R8: DAC bits are sampled on BCLK rising edges. Each captured word is zero-extended from the data width. Bits outside the receive slot's data bits have no effect on the captured words.
- R9: `dac_valid` pulses for exactly one system clock, once per frame. The pulse comes at the rising edge of the last bit of the receive slot: the right word's last bit, or the left word's last bit in mono. `dac_left` and `dac_right` change only together with that pulse.
- R10: With `mono`=1, only the left word is sent and the right-word position is released. The received left-position word appears on `dac_left`, and `dac_right` reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial bus |
| rst_n | input | 1 | Active-low synchronous reset |
| bclk | input | 1 | External bit clock |
| lrclk | input | 1 | External frame-sync pulse |
| dacdat | input | 1 | Serial DAC data in |
| adc_tdm_en | input | 1 | TDM enable for the transmit direction |
| dac_tdm_en | input | 1 | TDM enable for the receive direction |
| adc_slot | input | 1 | Transmit slot select |
| dac_slot | input | 1 | Receive slot select |
| sync_late | input | 1 | Framing variant: 1 puts the first bit on the first BCLK after the reference |
| mono | input | 1 | Left-position-only operation |
| dw_sel | input | 2 | Data width code |
| sl_sel | input | 2 | Slot word length code |
| adc_left | input | 32 | Left ADC word, right-justified |
| adc_right | input | 32 | Right ADC word, right-justified |
| adcdat | output | 1 | Serial ADC data out |
| adcdat_oe | output | 1 | Output enable for `adcdat` |
| dac_left | output | 32 | Captured left DAC word |
| dac_right | output | 32 | Captured right DAC word |
| dac_valid | output | 1 | One-cycle strobe for new DAC words |

## Verification
The hardest case to reach is a frame where the guard gap and the hand-off to the other slot's device both fall inside the same bit window. This only happens for particular pairings of slot length and data width under each framing variant. The bench therefore sweeps every legal width pairing against both framing variants and both slot choices. It models a second device that drives the other slot's data bits, and it fills every foreign bit on the DAC line with non-zero traffic. Overlap, early release and pickup of foreign bits all show up at the ports within a single frame.

// File: rtl/tdm_dsp_port.sv
module tdm_dsp_port (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bclk,
  input  logic        lrclk,
  input  logic        dacdat,
  input  logic        adc_tdm_en,
  input  logic        dac_tdm_en,
  input  logic        adc_slot,
  input  logic        dac_slot,
  input  logic        sync_late,
  input  logic        mono,
  input  logic [1:0]  dw_sel,
  input  logic [1:0]  sl_sel,
  input  logic [31:0] adc_left,
  input  logic [31:0] adc_right,
  output logic        adcdat,
  output logic        adcdat_oe,
  output logic [31:0] dac_left,
  output logic [31:0] dac_right,
  output logic        dac_valid
);
  localparam logic [7:0] POS_IDLE = 8'hFF;

  logic [2:0]  bclk_q;
  logic [1:0]  lr_q, dd_q;
  logic        lr_last, oe_q, dat_q;
  logic [7:0]  pos;
  logic [31:0] sh_l, sh_r, nxt_l, nxt_r;
  logic [5:0]  dw, sl;
  logic [8:0]  bidx;
  logic [7:0]  tx, rx;
  logic        rise, fall, sync;

  function automatic logic [5:0] width_of(input logic [1:0] code);
    case (code)
      2'd0: width_of = 6'd16;
      2'd1: width_of = 6'd20;
      2'd2: width_of = 6'd24;
      default: width_of = 6'd32;
    endcase
  endfunction

  function automatic logic [7:0] locate(input logic [8:0] b, input logic slot,
                                        input logic mn, input logic [5:0] w,
                                        input logic [5:0] l);
    logic [8:0] base, o, span, wp, l9;
    logic r;
    l9   = {3'b0, l};
    base = slot ? {2'b0, l, 1'b0} : 9'd0;
    o    = b - base;
    span = mn ? l9 : {2'b0, l, 1'b0};
    r    = o >= l9;
    wp   = r ? o - l9 : o;
    locate = 8'd0;
    if (b >= base && o < {2'b0, l, 1'b0}) begin
      locate[7]   = (o == span - 9'd1);
      locate[6]   = (wp < {3'b0, w}) && !(mn && r);
      locate[5]   = r;
      locate[4:0] = 5'(w - 6'd1 - wp[5:0]);
    end
  endfunction

  assign rise = bclk_q[1] & ~bclk_q[2];
  assign fall = ~bclk_q[1] & bclk_q[2];
  assign sync = rise & lr_q[1] & ~lr_last;
  assign dw   = width_of(dw_sel);
  assign sl   = width_of(sl_sel);
  assign bidx = {1'b0, pos} + 9'd1 - (sync_late ? 9'd1 : 9'd2);
  assign tx   = locate(bidx, adc_tdm_en & adc_slot, mono, dw, sl);
  assign rx   = locate(bidx, dac_tdm_en & dac_slot, mono, dw, sl);

  assign nxt_l = (rx[6] & ~rx[5]) ? {sh_l[30:0], dd_q[1]} : sh_l;
  assign nxt_r = (rx[6] &  rx[5]) ? {sh_r[30:0], dd_q[1]} : sh_r;

  assign adcdat    = dat_q;
  assign adcdat_oe = oe_q | ~adc_tdm_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bclk_q <= '0;
      lr_q   <= '0;
      dd_q   <= '0;
    end else begin
      bclk_q <= {bclk_q[1:0], bclk};
      lr_q   <= {lr_q[0], lrclk};
      dd_q   <= {dd_q[0], dacdat};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      oe_q  <= 1'b0;
      dat_q <= 1'b0;
    end else if (fall) begin
      oe_q  <= tx[6];
      dat_q <= tx[6] & (tx[5] ? adc_right[tx[4:0]] : adc_left[tx[4:0]]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lr_last   <= 1'b0;
      pos       <= POS_IDLE;
      sh_l      <= '0;
      sh_r      <= '0;
      dac_left  <= '0;
      dac_right <= '0;
      dac_valid <= 1'b0;
    end else begin
      dac_valid <= 1'b0;
      if (rise) begin
        lr_last <= lr_q[1];
        if (sync) begin
          pos  <= 8'd0;
          sh_l <= '0;
          sh_r <= '0;
        end else begin
          if (pos != POS_IDLE) pos <= pos + 8'd1;
          sh_l <= nxt_l;
          sh_r <= nxt_r;
          if (rx[7]) begin
            dac_valid <= 1'b1;
            dac_left  <= nxt_l;
            dac_right <= mono ? 32'd0 : nxt_r;
          end
        end
      end
    end
  end
endmodule

// File: rtl/tdm_dsp_port_chk.sv
module tdm_dsp_port_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        rise,
  input logic        fall,
  input logic        adc_tdm_en,
  input logic        adcdat,
  input logic        adcdat_oe,
  input logic        dac_valid,
  input logic [31:0] dac_left,
  input logic [31:0] dac_right
);
  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    dac_valid |=> !dac_valid); // R9
  AST_VALID_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    dac_valid |-> $past(rise)); // R9
  AST_WORDS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !dac_valid |-> ($stable(dac_left) && $stable(dac_right))); // R9
  AST_TX_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (adc_tdm_en && $past(adc_tdm_en) && !$past(fall)) |-> ($stable(adcdat) && $stable(adcdat_oe))); // R4
  AST_QUIET_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    (adc_tdm_en && !adcdat_oe) |-> !adcdat); // R5
endmodule

bind tdm_dsp_port tdm_dsp_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rise(rise), .fall(fall), .adc_tdm_en(adc_tdm_en),
  .adcdat(adcdat), .adcdat_oe(adcdat_oe), .dac_valid(dac_valid),
  .dac_left(dac_left), .dac_right(dac_right)
);

// File: tb/tdm_dsp_port_bench.sv
module tdm_dsp_port_bench;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, bclk, lrclk, dacdat, adc_tdm_en, dac_tdm_en, adc_slot, dac_slot;
  logic sync_late, mono;
  logic [1:0] dw_sel, sl_sel;
  logic [31:0] adc_left, adc_right, dac_left, dac_right;
  logic adcdat, adcdat_oe, dac_valid;

  tdm_dsp_port u_tdm_dsp_port (.*);

  int checks = 0, fails = 0, vcount = 0, frame_no = 0;
  localparam int FRAME_BITS = 136;

  always @(negedge clk) if (dac_valid) vcount++;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s frame %0d actual=%0h expected=%0h", req, frame_no, act, exp);
    end
  endtask

  function automatic int wl(int c);
    return (c == 0) ? 16 : (c == 1) ? 20 : (c == 2) ? 24 : 32;
  endfunction

  // returns -1 if no data bit, else right*256 + bit index within word
  function automatic int where(int b, int slot, int mn, int w, int l);
    int o, r, wp;
    o = b - slot * 2 * l;
    if (b < 0 || o < 0 || o >= 2 * l) return -1;
    r = (o >= l) ? 1 : 0;
    wp = o - r * l;
    if (wp >= w || (mn != 0 && r != 0)) return -1;
    return r * 256 + (w - 1 - wp);
  endfunction

  function automatic bit pick(int e, logic [31:0] lw, logic [31:0] rw);
    return (e >= 256) ? rw[e - 256] : lw[e];
  endfunction

  task automatic half_wait();
    repeat (6) @(posedge clk);
    #1;
  endtask

  task automatic run_frame(input int late, input int aslot, input int dslot, input int aen,
                           input int den, input int mn, input int dws, input int sls);
    int w, l, off, ts, rs, os, overlap;
    logic [31:0] rxl, rxr, mask;
    frame_no++;
    w = wl(dws); l = wl(sls); off = late ? 1 : 2;
    sync_late = late[0]; adc_slot = aslot[0]; dac_slot = dslot[0];
    adc_tdm_en = aen[0]; dac_tdm_en = den[0]; mono = mn[0];
    dw_sel = dws[1:0]; sl_sel = sls[1:0];
    adc_left  = 32'h9E3779B9 * (frame_no + 1);
    adc_right = 32'h7F4A7C15 ^ (frame_no * 32'h01010101);
    rxl = 32'hC2B2AE35 * (frame_no + 3);
    rxr = 32'h165667B1 + frame_no * 32'h3C6EF372;
    mask = (w == 32) ? 32'hFFFFFFFF : ((32'd1 << w) - 1);
    ts = aen ? aslot : 0; rs = den ? dslot : 0; os = 1 - ts;
    overlap = 0;
    vcount = 0;
    for (int n = 0; n < FRAME_BITS; n++) begin
      int b, e, d, x;
      b = n - off;
      bclk = 1'b0;
      lrclk = (n == 0);
      d = where(b, rs, mn, w, l);
      x = where(b, 1 - rs, mn, w, l);
      if (d >= 0) dacdat = pick(d, rxl, rxr);
      else if (x >= 0) dacdat = ~pick(x, rxl, rxr);
      else dacdat = n[0];
      half_wait();
      if (n >= 1) begin
        bit eoe, ed;
        e = where(b, ts, mn, w, l);
        eoe = (e >= 0) || (aen == 0);
        ed = (e >= 0) ? pick(e, adc_left, adc_right) : 1'b0;
        if (aen != 0)
          check(adcdat_oe == eoe && (!eoe || adcdat == ed),
                mn ? "R10 tx" : "R5 tx", {adcdat_oe, adcdat}, {eoe, ed});
        else
          check(adcdat_oe == 1'b1 && adcdat == ed, "R7 tx", {adcdat_oe, adcdat}, {1'b1, ed});
        if (aen != 0 && mn == 0 && where(b, os, 0, w, l) >= 0 && adcdat_oe) overlap++;
      end
      bclk = 1'b1;
      half_wait();
    end
    check(vcount == 1, "R9 strobe count", vcount, 1);
    check(dac_left == (rxl & mask), "R8 left word", dac_left, rxl & mask);
    check(dac_right == (mn ? 32'd0 : (rxr & mask)), mn ? "R10 right word" : "R8 right word",
          dac_right, mn ? 32'd0 : (rxr & mask));
    if (aen != 0 && mn == 0) check(overlap == 0, "R5 R6 overlap", overlap, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bclk = 1'b0; lrclk = 1'b0; dacdat = 1'b0;
    adc_tdm_en = 1'b1; dac_tdm_en = 1'b1; adc_slot = 1'b0; dac_slot = 1'b0;
    sync_late = 1'b0; mono = 1'b0; dw_sel = 2'd0; sl_sel = 2'd0;
    adc_left = 32'hFFFFFFFF; adc_right = 32'hFFFFFFFF;
    repeat (4) @(posedge clk);
    #1;
    check(adcdat_oe == 1'b0 && dac_valid == 1'b0, "R1 reset enables", {adcdat_oe, dac_valid}, 0);
    check(dac_left == 0 && dac_right == 0, "R1 reset words", dac_left | dac_right, 0);
    rst_n = 1'b1;
    for (int n = 0; n < 8; n++) begin
      bclk = 1'b0; dacdat = n[0];
      half_wait();
      check(adcdat_oe == 1'b0, "R2 no drive before sync", adcdat_oe, 0);
      bclk = 1'b1;
      half_wait();
    end
    check(vcount == 0 && dac_left == 0, "R2 no capture before sync", vcount, 0);
    for (int late = 0; late < 2; late++)
      for (int s = 0; s < 2; s++)
        for (int dws = 0; dws < 4; dws++)
          for (int sls = dws; sls < 4; sls++)
            run_frame(late, s, s ^ late, 1, 1, 0, dws, sls); // R2 R3 R5 R6 R8
    run_frame(0, 1, 0, 1, 1, 1, 2, 3);   // R10
    run_frame(1, 0, 1, 1, 1, 1, 0, 0);   // R10
    run_frame(0, 1, 1, 0, 0, 0, 2, 3);   // R7
    run_frame(1, 1, 1, 0, 0, 0, 3, 3);   // R7
    run_frame(0, 1, 1, 1, 0, 0, 1, 2);   // R6 R7
    run_frame(1, 0, 1, 0, 1, 0, 0, 3);   // R6 R7
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule